// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Compare Flag

This block is a 32-bit timer that counts down by one on each prescaled tick and raises a level interrupt when the count lands on a programmed compare value. Software reaches it through a plain word-addressed register bus with five words: control, status, load, compare and the live count. The tick comes from one of three external tick-enable inputs, or from none, and then passes through a 12-bit divider.

At zero the counter either restarts from the load register (reload mode) or wraps to all ones (free-running mode). Software picks how the counter starts when it is enabled. It can force a new load value into the running counter at once, or leave that value to take effect at the next reload. A software reset clears the timer state but keeps the enable bits and the low-power and debug enable bits. The bus carries the word index, which is the byte address with its two low bits dropped.

Top module: `dt_timer`

## Requirements
- R1: After hardware reset, control, status, compare and count read 0, load reads 0xFFFFFFFF and `irq` is low.
- R2: Word 0 is control, 1 is status, 2 is load, 3 is compare and 4 is count. Any other word reads 0, and writes to it change nothing. A control write stores only bits 25:0.
- R3: Control bits 25:24 select the tick. 00 gives no tick, so the counter is frozen. 01 selects `tick_periph`, 10 selects `tick_fast` and 11 selects `tick_slow`. The inputs that are not selected have no effect.
- R4: With prescale field value p (control bits 15:4), the counter steps once every p+1 selected ticks. The divider restarts from zero while the timer is disabled.
- R5: While enable (control bit 0) is set, each step lowers the count by one. Clearing enable freezes the count. Setting enable again with enable-mode (bit 1) clear resumes from the frozen value.
- R6: A control write that takes enable from 0 to 1 with enable-mode set loads the counter in that cycle. It loads the load register if reload mode (bit 3) is set, and 0xFFFFFFFF otherwise.
- R7: A step taken from a count of 0 loads the load register in reload mode and 0xFFFFFFFF in free-running mode.
- R8: A load write with overwrite (bit 17) set also puts the written value into the counter in the same cycle. Without overwrite the counter is left alone, and in reload mode the new value is first used at the next reload.
- R9: The status flag (bit 0) is set by each step whose new count equals the compare value. A count that merely matches while frozen does not set the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: A status write with bit 0 equal to 1 clears the flag. A status write with bit 0 equal to 0 has no effect.
- R11: `irq` is high exactly when the status flag, compare-interrupt enable (bit 2) and enable are all set.
- R12: A control write with bit 16 set performs a software reset. Status, compare and count become 0 and load becomes 0xFFFFFFFF. Control keeps only bits 0, 1, 18, 19, 20 and 21 of the written value, and bit 16 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick_periph | input | 1 | Tick enable, source 01 |
| tick_fast | input | 1 | Tick enable, source 10 |
| tick_slow | input | 1 | Tick enable, source 11 |
| bus_we | input | 1 | Write strobe |
| bus_word | input | 10 | Word index (byte address shifted right by 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the word index |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, enable-edge loads, overwrites and steps all take effect at the first rising edge after the stimulus is presented. The status flag and `irq` also change at that edge, because `irq` is decoded combinationally from registers. The bench drives each stimulus for exactly one cycle from a falling edge, then reads the affected register on the combinational read path shortly after the next falling edge. Every expected value is therefore one edge old. The prescaler sweep applies ticks one cycle at a time and predicts the count as all ones minus the integer quotient of ticks by p+1.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int CTRL_W = 26;
  localparam int PS_W   = 12;
  localparam int SRC_W  = 2;

  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int B_CIE    = 2;
  localparam int B_RLD    = 3;
  localparam int B_PS_LO  = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_DBG    = 18;
  localparam int B_WAIT   = 19;
  localparam int B_DOZE   = 20;
  localparam int B_STOP   = 21;
  localparam int B_SRC_LO = 24;

  typedef enum logic [2:0] {
    WD_CTRL = 3'd0,
    WD_STAT = 3'd1,
    WD_LOAD = 3'd2,
    WD_CMP  = 3'd3,
    WD_CNT  = 3'd4,
    WD_NONE = 3'd7
  } word_e;

  // control bits that survive a software reset
  function automatic logic [CTRL_W-1:0] swr_keep_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[B_EN]    = 1'b1;
    m[B_ENMOD] = 1'b1;
    m[B_DBG]   = 1'b1;
    m[B_WAIT]  = 1'b1;
    m[B_DOZE]  = 1'b1;
    m[B_STOP]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dt_tick_gen.sv
module dt_tick_gen
  import dt_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SRC_W-1:0] src,
  input  logic [NSRC-1:0]  ticks,
  input  logic [PS_W-1:0]  presc,
  output logic             step
);
  localparam int NV = NSRC + 1;

  logic [NV-1:0]   tick_vec;
  logic            sel_tick;
  logic [PS_W-1:0] pcnt;
  logic            wrap;

  // source 0 is the "no clock" slot
  assign tick_vec = {ticks, 1'b0};
  assign sel_tick = tick_vec[src];

  function automatic logic div_done(input logic [PS_W-1:0] c, input logic [PS_W-1:0] p);
    return c >= p;
  endfunction

  assign wrap = div_done(pcnt, presc);
  assign step = run & sel_tick & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (clr || !run)    pcnt <= '0;
    else if (sel_tick)       pcnt <= wrap ? '0 : pcnt + 1'b1;
  end

  p_step_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (sel_tick && src != '0));
  p_div_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt == '0);
endmodule

// File: rtl/dt_down_counter.sv
module dt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             force_ld,
  input  logic [CNT_W-1:0] force_val,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             step,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] nxt;
  logic             do_step;

  function automatic logic [CNT_W-1:0] step_value(
    input logic [CNT_W-1:0] cur, input logic rl, input logic [CNT_W-1:0] ldv);
    if (cur == '0) return rl ? ldv : ALL1;
    return cur - 1'b1;
  endfunction

  assign nxt     = step_value(cnt, reload_mode, load_val);
  assign do_step = step & ~clr & ~force_ld & ~start;
  assign hit     = do_step & (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (force_ld) cnt <= force_val;
    else if (start)    cnt <= start_val;
    else if (do_step)  cnt <= nxt;
  end

  p_step_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr && !force_ld && !start) |=> $stable(cnt));
  p_free_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && cnt == '0 && !reload_mode) |=> cnt == ALL1);
  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ld && !clr) |=> cnt == $past(force_val));
endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_periph,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_word,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam logic [CNT_W-1:0]  ALL1 = {CNT_W{1'b1}};
  localparam logic [CTRL_W-1:0] KEEP = swr_keep_mask();

  logic [CTRL_W-1:0] ctrl_q;
  logic              sts_q;
  logic [CNT_W-1:0]  ld_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt;

  word_e             wsel;
  logic [CTRL_W-1:0] ctrl_new;
  logic              ctrl_wr, stat_wr, load_wr, cmp_wr;
  logic              swr, en_rise, start, force_ld, step, hit;
  logic [CNT_W-1:0]  start_val;

  function automatic word_e decode(input logic [AW-1:0] w);
    if (w > AW'(4)) return WD_NONE;
    return word_e'(w[2:0]);
  endfunction

  assign wsel     = decode(bus_word);
  assign ctrl_wr  = bus_we && wsel == WD_CTRL;
  assign stat_wr  = bus_we && wsel == WD_STAT;
  assign load_wr  = bus_we && wsel == WD_LOAD;
  assign cmp_wr   = bus_we && wsel == WD_CMP;
  assign ctrl_new = bus_wdata[CTRL_W-1:0];

  assign swr       = ctrl_wr && ctrl_new[B_SWR];
  assign en_rise   = ctrl_wr && !swr && ctrl_new[B_EN] && !ctrl_q[B_EN];
  assign start     = en_rise && ctrl_new[B_ENMOD];
  assign start_val = ctrl_new[B_RLD] ? ld_q : ALL1;
  assign force_ld  = load_wr && ctrl_q[B_OVW];

  dt_tick_gen #(.NSRC(3)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q[B_EN]),
    .clr   (swr),
    .src   (ctrl_q[B_SRC_LO +: SRC_W]),
    .ticks ({tick_slow, tick_fast, tick_periph}),
    .presc (ctrl_q[B_PS_LO +: PS_W]),
    .step  (step)
  );

  dt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (swr),
    .force_ld    (force_ld),
    .force_val   (bus_wdata),
    .start       (start),
    .start_val   (start_val),
    .step        (step),
    .reload_mode (ctrl_q[B_RLD]),
    .load_val    (ld_q),
    .cmp_val     (cmp_q),
    .cnt         (cnt),
    .hit         (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sts_q  <= 1'b0;
      ld_q   <= ALL1;
      cmp_q  <= '0;
    end else if (swr) begin
      ctrl_q <= ctrl_new & KEEP;
      sts_q  <= 1'b0;
      ld_q   <= ALL1;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_new;
      if (load_wr) ld_q   <= bus_wdata;
      if (cmp_wr)  cmp_q  <= bus_wdata;
      if (hit)                          sts_q <= 1'b1;
      else if (stat_wr && bus_wdata[0]) sts_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (wsel)
      WD_CTRL: bus_rdata = CNT_W'(ctrl_q);
      WD_STAT: bus_rdata = CNT_W'(sts_q);
      WD_LOAD: bus_rdata = ld_q;
      WD_CMP:  bus_rdata = cmp_q;
      WD_CNT:  bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = sts_q & ctrl_q[B_CIE] & ctrl_q[B_EN];

  p_hit_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !swr) |=> sts_q);
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[0] && !hit) |=> !sts_q);
  p_swr_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (ld_q == ALL1 && cmp_q == '0 && cnt == '0 && !ctrl_q[B_SWR]));
  p_start_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(start_val));
  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_EN] |-> !irq);
  p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word > AW'(4)) |-> bus_rdata == '0);
endmodule

// File: tb/sim_dt_timer.sv
module sim_dt_timer;
  localparam time PERIOD = 10ns;
  localparam logic [31:0] EN = 32'h1, ENM = 32'h2, CIE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000;
  localparam logic [31:0] SP = 32'h0100_0000, SF = 32'h0200_0000, SS = 32'h0300_0000;
  localparam logic [31:0] M1 = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic tp = 0, tf = 0, ts = 0, we = 0;
  logic [9:0]  word = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int errors = 0, checks = 0;

  dt_timer u0 (.clk(clk), .rst_n(rst_n), .tick_periph(tp), .tick_fast(tf),
    .tick_slow(ts), .bus_we(we), .bus_word(word), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    we = 1; word = 10'(w); wdata = d;
    @(negedge clk); we = 0; word = '0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    word = 10'(w); #1; d = rdata;
  endtask

  task automatic rchk(input string tag, input int w, input logic [31:0] exp);
    logic [31:0] d;
    rd(w, d); chk(tag, d, exp);
  endtask

  task automatic tick(input int which);
    tp = (which == 1); tf = (which == 2); ts = (which == 3);
    @(negedge clk); tp = 0; tf = 0; ts = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset values
    rchk("R1 ctrl", 0, 0); rchk("R1 stat", 1, 0); rchk("R1 load", 2, M1);
    rchk("R1 cmp", 3, 0);  rchk("R1 cnt", 4, 0);  chk("R1 irq", 32'(irq), 0);

    // R6 start from load in reload mode
    wr(2, 10); wr(3, 5);
    wr(0, EN|ENM|CIE|RLD|SP);
    rchk("R6 start load", 4, 10);
    rchk("R2 ctrl readback", 0, EN|ENM|CIE|RLD|SP);
    for (int k = 1; k <= 10; k++) begin
      tick(1);
      rchk("R5 dec", 4, 32'(10 - k));
      if (k == 4) rchk("R9 no flag yet", 1, 0);
      if (k == 5) begin rchk("R9 flag on match", 1, 1); chk("R11 irq on", 32'(irq), 1); end
    end
    wr(1, 0); rchk("R10 write 0 ignored", 1, 1);
    wr(1, 1); rchk("R10 clear", 1, 0); chk("R11 irq off after clear", 32'(irq), 0);
    tick(1); rchk("R7 reload at zero", 4, 10);

    // R8 deferred load without overwrite
    wr(2, 20); rchk("R8 no overwrite", 4, 10);
    for (int k = 0; k < 10; k++) tick(1);
    rchk("R8 reached zero", 4, 0);
    tick(1); rchk("R8 new load at reload", 4, 20);
    wr(1, 1);

    // R11 gating by compare-interrupt enable
    wr(3, 19); tick(1);
    rchk("R9 flag 19", 1, 1); chk("R11 irq", 32'(irq), 1);
    wr(0, EN|ENM|RLD|SP);
    chk("R11 irq gated", 32'(irq), 0); rchk("R11 flag kept", 1, 1);
    rchk("R6 no restart while enabled", 4, 19);
    wr(1, 1);

    // R5 freeze and resume; R9 frozen match
    wr(0, RLD|SP); tick(1); rchk("R5 frozen", 4, 19);
    wr(3, 19); tick(1); rchk("R9 frozen match no flag", 1, 0);
    wr(0, EN|RLD|SP); rchk("R5 resume value", 4, 19);
    tick(1); rchk("R5 resumed dec", 4, 18);

    // R9 set beats clear in the same cycle
    wr(3, 17);
    tp = 1; we = 1; word = 10'd1; wdata = 1;
    @(negedge clk); tp = 0; we = 0; word = '0;
    rchk("R9 set wins", 1, 1); rchk("R9 cnt", 4, 17);
    wr(1, 1);

    // R6 free-run start, R8 overwrite, R7 wrap
    wr(0, 0); wr(0, EN|ENM|SP|OVW);
    rchk("R6 start all ones", 4, M1);
    tick(1); rchk("R5 dec from ones", 4, 32'hFFFF_FFFE);
    wr(2, 1); rchk("R8 overwrite", 4, 1);
    tick(1); rchk("R7 at zero", 4, 0);
    tick(1); rchk("R7 free wrap", 4, M1);

    // R3 source select
    wr(0, 0); wr(0, EN|ENM|SF);
    tick(1); tick(3); rchk("R3 fast ignores others", 4, M1);
    tick(2); rchk("R3 fast ticks", 4, 32'hFFFF_FFFE);
    wr(0, 0); wr(0, EN|ENM|SS);
    tick(1); tick(2); rchk("R3 slow ignores others", 4, M1);
    tick(3); rchk("R3 slow ticks", 4, 32'hFFFF_FFFE);
    wr(0, 0); wr(0, EN|ENM);
    tick(1); tick(2); tick(3); rchk("R3 no source frozen", 4, M1);

    // R4 prescaler sweep
    for (int p = 0; p < 4; p++) begin
      wr(0, 0); wr(0, EN|ENM|SP|(32'(p) << 4));
      for (int k = 1; k <= 3 * (p + 1); k++) begin
        tick(1);
        rchk("R4 prescale", 4, M1 - 32'(k / (p + 1)));
      end
    end

    // R2 decode and mask
    rchk("R2 word5 reads 0", 5, 0); rchk("R2 word7 reads 0", 7, 0);
    wr(7, 32'h55); wr(5, 32'h66);
    rchk("R2 load untouched", 2, 1); rchk("R2 cmp untouched", 3, 17);
    wr(0, 32'hFC00_0000 | SP); rchk("R2 ctrl mask", 0, SP);

    // R12 software reset
    wr(3, 32'hFFFF_FFFE); wr(0, EN|ENM|SP);
    tick(1); rchk("R12 pre flag", 1, 1);
    wr(0, EN|ENM|CIE|RLD|SWR|OVW|(32'h9 << 18)|SP|(32'h5 << 4));
    rchk("R12 ctrl kept", 0, EN|ENM|(32'h9 << 18));
    rchk("R12 stat", 1, 0); rchk("R12 load", 2, M1);
    rchk("R12 cmp", 3, 0);  rchk("R12 cnt", 4, 0);
    tick(1); rchk("R12 no source after reset", 4, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule